// File: doc/BRIEF.md
# SPI Flash Read Sequencer

This block carries out a complete serial flash read on its own. A client hands it a 24-bit start address and a byte count through a one-shot request handshake. The block lowers chip select, sends the read command and the address, then keeps the bus clocked with filler bytes until the requested number of data bytes has come back. The bytes that the flash returns while the command and address are still going out carry no meaning, and the block drops them. Only real data reaches the client, on a valid/ready byte stream.

The serial side runs in SPI mode 0, with a clock divider that is set for each request. The block keeps a single-byte holding register on the output. It starts a new filler byte only when that register is empty and no earlier byte is still in flight, so a slow consumer stalls the bus instead of losing data. When the last data byte has been received, chip select is raised and a one-cycle done pulse is given.

Top module: `spi_flash_reader`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, dout_valid is 0, done is 0 and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 0 while a read is under way. For a nonzero count, spi_cs_n is 0 and spi_sclk is still 0 in the cycle after acceptance, and chip select falls exactly once per read.
- R3: The first 32 bits shifted out on spi_mosi, most significant bit first, are the opcode 0x03 followed by req_addr[23:16], req_addr[15:8] and req_addr[7:0].
- R4: spi_sclk idles low. Each high phase lasts sclk_div+1 clock cycles, with the divider value taken when the request is accepted. spi_miso is sampled as spi_sclk rises, and spi_mosi changes only while spi_sclk falls or is idle.
- R5: The four bytes received during the command phase are never delivered. dout_data carries exactly req_len bytes, in the order they arrive from the flash.
- R6: After the address, exactly req_len filler bytes of value 0x00 are sent, so one read makes 8*(req_len+4) rising edges of spi_sclk.
- R7: A filler byte is not launched while the output holding register is occupied or an earlier byte is in flight. With dout_ready held at 0, the bus stops after the first data byte (40 rising edges) and no data byte is lost.
- R8: While dout_valid is 1 and dout_ready is 0, dout_valid stays 1 and dout_data is unchanged on the next cycle.
- R9: spi_cs_n returns to 1 once the last data byte has been received. done is a one-cycle pulse in the first cycle with spi_cs_n back at 1, and it occurs exactly once per read.
- R10: A request with req_len of 0 gives a done pulse in the cycle after acceptance. spi_cs_n never goes low and spi_sclk never toggles.
- R11: spi_sclk is never 1 while spi_cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 24 | Flash start address |
| req_len | input | LEN_W | Number of data bytes to read |
| sclk_div | input | DIV_W | SCLK half period minus one, in clock cycles |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| dout_valid | output | 1 | Data byte available |
| dout_ready | input | 1 | Consumer takes the data byte |
| dout_data | output | 8 | Data byte |
| done | output | 1 | One-cycle pulse when the read ends |

## Verification
The checker assumes two things about the consumer and the flash. The consumer may hold dout_ready low for any length of time. spi_miso is driven in mode 0 and changes only while spi_sclk falls. The bench flash model meets this by updating its output only on falling edges of spi_sclk, and it drives all ones during the command phase so that a leaked dummy byte would show up. The stimulus raises req_valid only while the sequencer is idle and changes sclk_div only together with a new request, so the stable-hold property and the no-overflow property are tested against the ready patterns the block is built for.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  localparam logic [7:0] READ_OP   = 8'h03;
  localparam logic [7:0] FILL_BYTE = 8'h00;
  localparam int         CMD_BYTES = 4;

endpackage

// File: rtl/spi_mode0_shifter.sv
module spi_mode0_shifter #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [7:0]       tx_byte,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic [7:0]       rx_byte,
  output logic             rx_done
);

  logic             active_q, active_d;
  logic             sclk_q, sclk_d;
  logic             done_q, done_d;
  logic [DIV_W-1:0] tick_q, tick_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       tx_q, tx_d;
  logic [7:0]       rx_q, rx_d;
  logic             half;

  assign half = (tick_q == div);

  always_comb begin
    active_d = active_q;
    sclk_d   = sclk_q;
    tick_d   = tick_q;
    bit_d    = bit_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    done_d   = 1'b0;
    if (go) begin
      active_d = 1'b1;
      sclk_d   = 1'b0;
      tick_d   = '0;
      bit_d    = '0;
      tx_d     = tx_byte;
    end else if (active_q) begin
      if (half) begin
        tick_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[6:0], miso};
        end else begin
          sclk_d = 1'b0;
          if (bit_q == 3'd7) begin
            active_d = 1'b0;
            done_d   = 1'b1;
          end else begin
            bit_d = bit_q + 3'd1;
            tx_d  = {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      tick_q   <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      active_q <= active_d;
      sclk_q   <= sclk_d;
      done_q   <= done_d;
      tick_q   <= tick_d;
      bit_q    <= bit_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_q[7];
  assign rx_byte = rx_q;
  assign rx_done = done_q;

endmodule

// File: rtl/rd_out_slot.sv
module rd_out_slot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       full,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);

  logic       full_q, full_d;
  logic [7:0] data_q, data_d;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (wr) begin
      full_d = 1'b1;
      data_d = wdata;
    end else if (full_q && out_ready) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full      = full_q;
  assign out_valid = full_q;
  assign out_data  = data_q;

endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader
  import spi_rd_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [DIV_W-1:0] sclk_div,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             dout_valid,
  input  logic             dout_ready,
  output logic [7:0]       dout_data,
  output logic             done
);

  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] CMD_CNT = CNT_W'(CMD_BYTES);

  seq_state_e       state_q, state_d;
  logic             cs_n_q, cs_n_d;
  logic             done_q, done_d;
  logic [23:0]      addr_q, addr_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic [CNT_W-1:0] tx_cnt_q, tx_cnt_d;
  logic [CNT_W-1:0] rx_cnt_q, rx_cnt_d;

  logic       launch, finish, rx_fill, slot_full, rx_done;
  logic [7:0] tx_byte, rx_byte;
  logic [1:0] cmd_idx;

  assign req_ready = (state_q == SEQ_IDLE);
  assign cmd_idx   = tx_cnt_q[1:0];
  assign launch    = (state_q == SEQ_RUN) && (tx_cnt_q == rx_cnt_q) &&
                     (tx_cnt_q < total_q) &&
                     ((tx_cnt_q < CMD_CNT) || !slot_full);
  assign finish    = (state_q == SEQ_RUN) && (rx_cnt_q == total_q);
  assign rx_fill   = rx_done && (rx_cnt_q >= CMD_CNT);

  always_comb begin
    tx_byte = FILL_BYTE;
    if (tx_cnt_q < CMD_CNT) begin
      case (cmd_idx)
        2'd0:    tx_byte = READ_OP;
        2'd1:    tx_byte = addr_q[23:16];
        2'd2:    tx_byte = addr_q[15:8];
        default: tx_byte = addr_q[7:0];
      endcase
    end
  end

  always_comb begin
    state_d  = state_q;
    cs_n_d   = cs_n_q;
    done_d   = 1'b0;
    addr_d   = addr_q;
    div_d    = div_q;
    total_d  = total_q;
    tx_cnt_d = tx_cnt_q;
    rx_cnt_d = rx_cnt_q;
    case (state_q)
      SEQ_IDLE: begin
        if (req_valid) begin
          if (req_len == '0) begin
            done_d = 1'b1;
          end else begin
            state_d  = SEQ_RUN;
            cs_n_d   = 1'b0;
            addr_d   = req_addr;
            div_d    = sclk_div;
            total_d  = CNT_W'(req_len) + CMD_CNT;
            tx_cnt_d = '0;
            rx_cnt_d = '0;
          end
        end
      end
      default: begin
        if (launch)  tx_cnt_d = tx_cnt_q + 1'b1;
        if (rx_done) rx_cnt_d = rx_cnt_q + 1'b1;
        if (finish) begin
          state_d = SEQ_IDLE;
          cs_n_d  = 1'b1;
          done_d  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      cs_n_q   <= 1'b1;
      done_q   <= 1'b0;
      addr_q   <= '0;
      div_q    <= '0;
      total_q  <= '0;
      tx_cnt_q <= '0;
      rx_cnt_q <= '0;
    end else begin
      state_q  <= state_d;
      cs_n_q   <= cs_n_d;
      done_q   <= done_d;
      addr_q   <= addr_d;
      div_q    <= div_d;
      total_q  <= total_d;
      tx_cnt_q <= tx_cnt_d;
      rx_cnt_q <= rx_cnt_d;
    end
  end

  spi_mode0_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (launch),
    .tx_byte (tx_byte),
    .div     (div_q),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .rx_byte (rx_byte),
    .rx_done (rx_done)
  );

  rd_out_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (rx_fill),
    .wdata     (rx_byte),
    .full      (slot_full),
    .out_valid (dout_valid),
    .out_ready (dout_ready),
    .out_data  (dout_data)
  );

  assign spi_cs_n = cs_n_q;
  assign done     = done_q;

endmodule

// File: rtl/spi_rd_chk.sv
module spi_rd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic       req_ready,
  input logic       dout_valid,
  input logic       dout_ready,
  input logic [7:0] dout_data,
  input logic       done,
  input logic       rx_fill,
  input logic       slot_full
);

  // R11
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

  // R9
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n);

  // R9
  cs_rise_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> done);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fill |-> !slot_full);

  // R2
  idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n);

endmodule

bind spi_flash_reader spi_rd_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_cs_n   (spi_cs_n),
  .spi_sclk   (spi_sclk),
  .req_ready  (req_ready),
  .dout_valid (dout_valid),
  .dout_ready (dout_ready),
  .dout_data  (dout_data),
  .done       (done),
  .rx_fill    (rx_fill),
  .slot_full  (slot_full)
);

// File: tb/spi_flash_reader_test.sv
`timescale 1ns/1ps
module spi_flash_reader_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_addr;
  logic [15:0] req_len;
  logic [3:0]  sclk_div;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso;
  logic        dout_valid;
  logic        dout_ready;
  logic [7:0]  dout_data;
  logic        done;

  int total = 0;
  int bad = 0;

  logic [31:0] cmd_sr;
  int nbits = 0, fill_ones = 0, rises = 0, cs_falls = 0;
  int hi_run = 0, max_hi = 0, done_cnt = 0, done_bad = 0;
  int ngot = 0, cyc = 0, rmode = 0;
  logic [7:0] got [0:63];

  // vector: {addr[23:0], len[7:0], div[3:0], ready_mode[1:0]}
  localparam logic [37:0] VECS [0:4] = '{
    {24'h123456, 8'd5, 4'd0, 2'd0},
    {24'hFFFFFE, 8'd4, 4'd2, 2'd1},
    {24'h000000, 8'd1, 4'd1, 2'd2},
    {24'hA5C3E1, 8'd8, 4'd3, 2'd2},
    {24'h7F0080, 8'd3, 4'd0, 2'd1}
  };

  always #10 clk = ~clk;

  spi_flash_reader #(.LEN_W(16), .DIV_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .sclk_div(sclk_div),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .dout_valid(dout_valid), .dout_ready(dout_ready),
    .dout_data(dout_data), .done(done)
  );

  function automatic logic [7:0] expd(logic [23:0] a, int k);
    return (a[7:0] + 8'(k)) ^ a[15:8];
  endfunction

  function automatic logic model_bit(int n);
    logic [7:0] d;
    if (n < 32) return 1'b1;
    d = expd(cmd_sr[23:0], (n - 32) / 8);
    return d[7 - ((n - 32) % 8)];
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // flash model
  always @(negedge spi_cs_n) begin
    nbits = 0;
    spi_miso = 1'b1;
    cs_falls++;
  end
  always @(posedge spi_sclk) begin
    rises++;
    if (!spi_cs_n) begin
      if (nbits < 32) cmd_sr = {cmd_sr[30:0], spi_mosi};
      else if (spi_mosi) fill_ones++;
      nbits++;
    end
  end
  always @(negedge spi_sclk) if (!spi_cs_n) spi_miso = model_bit(nbits);

  // consumer and monitors
  always @(posedge clk) begin
    if (dout_valid && dout_ready) begin
      if (ngot < 64) got[ngot] = dout_data;
      ngot++;
    end
    if (done) begin
      done_cnt++;
      if (!spi_cs_n) done_bad++;
    end
    if (spi_sclk) hi_run++;
    else begin
      if (hi_run > max_hi) max_hi = hi_run;
      hi_run = 0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    case (rmode)
      0:       dout_ready = 1'b1;
      1:       dout_ready = (cyc % 2 == 0);
      2:       dout_ready = (cyc % 4 == 0);
      default: dout_ready = 1'b0;
    endcase
  end

  task automatic start_req(logic [23:0] a, int n, int dv);
    @(negedge clk);
    req_addr  = a;
    req_len   = 16'(n);
    sclk_div  = 4'(dv);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_txn(logic [23:0] a, int n, int dv, int md);
    int r0, f0, miss;
    @(negedge clk);
    rmode = md; ngot = 0; done_cnt = 0; done_bad = 0; fill_ones = 0; max_hi = 0;
    r0 = rises; f0 = cs_falls;
    start_req(a, n, dv);
    chk(spi_cs_n == 1'b0 && spi_sclk == 1'b0 && req_ready == 1'b0, "R2",
        "cs low, sclk low, busy after accept", {spi_cs_n, spi_sclk, req_ready}, 0);
    for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk);
    for (int i = 0; i < 2000 && ngot < n; i++) @(negedge clk);
    chk(cmd_sr == {8'h03, a}, "R3", "opcode and address", cmd_sr, {8'h03, a});
    chk(ngot == n, "R5", "data byte count", ngot, n);
    miss = 0;
    for (int k = 0; k < n && k < 64; k++) if (got[k] !== expd(a, k)) miss++;
    chk(miss == 0, "R5", "data bytes in order, dummies dropped", miss, 0);
    chk(rises - r0 == 8 * (n + 4), "R6", "sclk rising edges", rises - r0, 8 * (n + 4));
    chk(fill_ones == 0, "R6", "filler bits are zero", fill_ones, 0);
    chk(done_cnt == 1 && done_bad == 0, "R9", "single done with cs high",
        done_cnt, 1);
    chk(spi_cs_n == 1'b1 && cs_falls - f0 == 1, "R9", "cs released, one frame",
        cs_falls - f0, 1);
    chk(max_hi == dv + 1, "R4", "sclk high phase length", max_hi, dv + 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; sclk_div = '0;
    spi_miso = 1'b0; dout_ready = 1'b1; cmd_sr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1 && spi_sclk == 0 && dout_valid == 0 && done == 0 && req_ready == 1,
        "R1", "reset state", {spi_cs_n, spi_sclk, dout_valid, done, req_ready}, 5'b10001);

    for (int v = 0; v < 5; v++)
      run_txn(VECS[v][37:14], int'(VECS[v][13:6]), int'(VECS[v][5:2]), int'(VECS[v][1:0]));

    // R10 zero-length request
    begin
      int r0, f0;
      r0 = rises; f0 = cs_falls; done_cnt = 0; rmode = 0;
      start_req(24'h000100, 0, 1);
      chk(done == 1'b1 && spi_cs_n == 1'b1, "R10", "done next cycle, cs high",
          {done, spi_cs_n}, 2'b11);
      repeat (50) @(negedge clk);
      chk(rises == r0 && cs_falls == f0, "R10", "no bus activity",
          rises - r0 + cs_falls - f0, 0);
      chk(done_cnt == 1 && req_ready == 1'b1, "R10", "single done, idle", done_cnt, 1);
    end

    // R7 backpressure: bus stops after first data byte
    begin
      int r0, miss;
      r0 = rises; ngot = 0; done_cnt = 0; rmode = 3;
      start_req(24'h00ABCD, 3, 1);
      repeat (3000) @(negedge clk);
      chk(rises - r0 == 40, "R7", "bus halts with full slot", rises - r0, 40);
      chk(dout_valid == 1'b1 && dout_data == expd(24'h00ABCD, 0), "R8",
          "held byte", dout_data, expd(24'h00ABCD, 0));
      chk(spi_cs_n == 1'b0 && done_cnt == 0, "R7", "frame stays open", spi_cs_n, 0);
      rmode = 0;
      for (int i = 0; i < 5000 && (done_cnt == 0 || ngot < 3); i++) @(negedge clk);
      miss = 0;
      for (int k = 0; k < 3; k++) if (got[k] !== expd(24'h00ABCD, k)) miss++;
      chk(ngot == 3 && miss == 0, "R7", "no byte lost after stall", ngot * 16 + miss, 48);
      chk(rises - r0 == 56, "R6", "edges after stall", rises - r0, 56);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule